// File: doc/BRIEF.md
# Passive Panel Output Shifter

This block sits between the dither stage of a display pipeline and the data pins of a passive-matrix panel. Each modulated pixel arrives as a 4-bit nibble with a valid strobe. A packing shifter turns the nibbles into panel words. On a 4-line bus every nibble becomes a word of its own. On an 8-line bus two consecutive nibbles make one word. The finished words wait in a two-entry output buffer until the panel timing asks for them.

Colour panels always use the full 8-line bus. Monochrome panels may use either width. When an active-matrix panel is selected, the shifter and the buffer are skipped, and pixel data already formatted upstream goes straight to the pins. Leaving passive mode empties the buffer and drops any half-built word.

Top module: `passive_pixel_packer`

## Requirements
- R1: After reset the buffer is empty. `panel_shift_en` is low and `pix_ready` is high while passive mode is selected.
- R2: On a 4-line monochrome bus (`color_mode`=0, `wide_bus`=0), each accepted nibble becomes one word. Bits [3:0] hold the nibble and bits [7:4] are zero.
- R3: On an 8-line bus, two accepted nibbles form one word. The first goes to bits [7:4] and the second to bits [3:0].
- R4: `color_mode`=1 selects 8-line packing whatever the value of `wide_bus`.
- R5: The buffer holds at most two words and delivers them in the order they were completed.
- R6: When the buffer is full and the next nibble would complete a word, `pix_ready` is low. The stalled nibble is accepted once a word has left, and it is not lost.
- R7: In passive mode, `panel_shift_en` is high in exactly the cycles where `panel_take` is high and the buffer is not empty. `panel_data` then shows the oldest word, and is zero otherwise.
- R8: While `active_mode`=1, `panel_data` follows `act_data` and `panel_shift_en` follows `act_valid` in the same cycle, and `pix_ready` is low. The buffer and any half-built word are cleared.
- R9: On an 8-line bus, the first nibble of a word is accepted even when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_mode | input | 1 | 1 selects active-matrix bypass |
| color_mode | input | 1 | 1 selects a colour panel, which forces 8-line packing |
| wide_bus | input | 1 | Monochrome bus width: 1 selects 8 lines, 0 selects 4 lines |
| pix_in | input | NIB_W | Modulated pixel nibble |
| pix_valid | input | 1 | Nibble valid |
| pix_ready | output | 1 | Nibble is accepted at this edge if valid |
| act_data | input | 2*NIB_W | Active-matrix pixel data to pass through |
| act_valid | input | 1 | Active-matrix data valid |
| panel_take | input | 1 | Panel timing requests one word this cycle |
| panel_data | output | 2*NIB_W | Data driven to the panel pins |
| panel_shift_en | output | 1 | Shift clock enable for the panel |

## Verification
The bench builds the block with its defaults: 4-bit nibbles and a two-word buffer. At these sizes every nibble value on the narrow bus, and every one of the 256 nibble pairs on the wide bus, can be swept in full. With only two entries, the full and stall conditions are reached after a handful of pixels. This lets the bench cover stalls in both packing modes, the colour override, and the flush on entry to bypass, each at the exact cycle where it applies.

// File: rtl/passive_pixel_packer.sv
module passive_pixel_packer #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_mode,
  input  logic               color_mode,
  input  logic               wide_bus,
  input  logic [NIB_W-1:0]   pix_in,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [2*NIB_W-1:0] act_data,
  input  logic               act_valid,
  input  logic               panel_take,
  output logic [2*NIB_W-1:0] panel_data,
  output logic               panel_shift_en
);
  localparam int WORD_W = 2 * NIB_W;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic              half;
  logic [NIB_W-1:0]  hold;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;

  wire wide      = color_mode | wide_bus;
  wire full      = (count == CW'(DEPTH));
  wire empty     = (count == '0);
  wire completes = ~wide | half;
  wire accept    = pix_valid & pix_ready;
  wire push      = accept & completes;
  wire pop       = ~active_mode & panel_take & ~empty;
  wire [WORD_W-1:0] new_word = wide ? {hold, pix_in} : {{NIB_W{1'b0}}, pix_in};

  assign pix_ready      = ~active_mode & (~full | ~completes);
  assign panel_shift_en = active_mode ? act_valid : pop;
  assign panel_data     = active_mode ? act_data : (pop ? mem[rd_ptr] : '0);

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || active_mode) begin
      half   <= 1'b0;
      hold   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) begin
        if (completes) half <= 1'b0;
        else begin
          hold <= pix_in;
          half <= 1'b1;
        end
      end
      if (push) wr_ptr <= adv(wr_ptr);
      if (pop)  rd_ptr <= adv(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= new_word;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_bypass_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode |-> !pix_ready);

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode |=> (count == '0) && !half);

  assert_shift_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_shift_en && !active_mode) |-> (count != '0));

  assert_pair_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wide && !half) |=> half);
endmodule

// File: tb/sim_passive_pixel_packer.sv
module sim_passive_pixel_packer;
  logic clk = 0, rst_n = 0;
  logic active_mode = 0, color_mode = 0, wide_bus = 0;
  logic [3:0] pix_in = 0;
  logic pix_valid = 0;
  logic pix_ready;
  logic [7:0] act_data = 0;
  logic act_valid = 0, panel_take = 0;
  logic [7:0] panel_data;
  logic panel_shift_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  passive_pixel_packer u0 (
    .clk(clk), .rst_n(rst_n), .active_mode(active_mode), .color_mode(color_mode),
    .wide_bus(wide_bus), .pix_in(pix_in), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .act_data(act_data), .act_valid(act_valid), .panel_take(panel_take),
    .panel_data(panel_data), .panel_shift_en(panel_shift_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] v);
    @(negedge clk);
    pix_in = v; pix_valid = 1;
    #1;
    for (int i = 0; i < 20 && !pix_ready; i++) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    pix_valid = 0;
  endtask

  task automatic pull(input string req, input logic [7:0] exp);
    @(negedge clk);
    panel_take = 1;
    #1;
    chk(req, {23'd0, panel_shift_en, panel_data}, {23'd0, 1'b1, exp});
    @(posedge clk); #1;
    panel_take = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R1 reset state
    chk("R1", {panel_shift_en, pix_ready}, 2'b01);
    panel_take = 1; #1;
    chk("R1 empty", {panel_shift_en, panel_data}, 9'd0);
    panel_take = 0;

    // R2 narrow sweep
    for (int v = 0; v < 16; v++) begin
      send(4'(v));
      pull("R2", 8'(v));
    end

    // R3 wide sweep, all pairs
    wide_bus = 1;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        send(4'(a)); send(4'(b));
        pull("R3", {4'(a), 4'(b)});
      end

    // R4 colour forces wide
    wide_bus = 0; color_mode = 1;
    for (int a = 0; a < 16; a++) begin
      send(4'(a)); send(4'(15 - a));
      pull("R4", {4'(a), 4'(15 - a)});
    end
    color_mode = 0;

    // R5/R6 narrow fill and stall
    send(4'h3); send(4'h9);
    @(negedge clk); pix_in = 4'h5; pix_valid = 1; #1;
    chk("R6 stall", pix_ready, 1'b0);
    @(posedge clk); #1;
    chk("R6 held", pix_ready, 1'b0);
    pix_valid = 0;
    pull("R5 order", 8'h03);
    send(4'h5);
    pull("R5 order", 8'h09);
    pull("R6 not lost", 8'h05);
    @(negedge clk); panel_take = 1; #1;
    chk("R7 empty", {panel_shift_en, panel_data}, 9'd0);
    panel_take = 0;

    // R9 wide: first nibble accepted while full
    wide_bus = 1;
    send(4'hA); send(4'hB); send(4'hC); send(4'hD);
    @(negedge clk); pix_in = 4'hE; pix_valid = 1; #1;
    chk("R9 first ok", pix_ready, 1'b1);
    @(posedge clk); #1;
    pix_in = 4'hF; #1;
    chk("R6 wide stall", pix_ready, 1'b0);
    pix_valid = 0;
    pull("R5 wide", 8'hAB);
    send(4'hF);
    pull("R5 wide", 8'hCD);
    pull("R9 pair", 8'hEF);

    // R8 bypass and flush
    send(4'h1); send(4'h2); send(4'h4);
    @(negedge clk); active_mode = 1;
    for (int v = 0; v < 8; v++) begin
      act_data = 8'(v * 37); act_valid = v[0]; #1;
      chk("R8 pass", {pix_ready, panel_shift_en, panel_data}, {1'b0, v[0], 8'(v * 37)});
      @(negedge clk);
    end
    active_mode = 0; act_valid = 0; panel_take = 1; #1;
    chk("R8 flushed", {panel_shift_en, pix_ready}, 2'b01);
    panel_take = 0;
    send(4'h6); send(4'h7);
    pull("R8 half dropped", 8'h67);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule